// File: doc/BRIEF.md
# Lock-Aware TLB Maintenance Controller

This block is a small fully associative translation buffer with a register window for software maintenance. Every slot holds a virtual tag, a physical page number, a valid flag and a lock flag. A lookup port translates a virtual tag in the same cycle. Software writes a command word to find a tag, to invalidate all slots, to invalidate only the slots that are not locked, or to copy the current replacement victim into the allocation index. The allocation index is a read-only field of the command word. It names the slot that the entry write port fills next. A translation fault can also load the allocation index directly.

Replacement uses a round-robin pointer. The victim is the first slot that is not locked, counting from the pointer. Locked slots are never chosen as victims. Lookups and search commands never move the pointer. Only an entry write moves it. The slot count must be a power of two so that the pointer wraps naturally.

Top module: `tlb_maint_ctrl`

## Requirements
- R1: After a synchronous reset, every slot is invalid and unlocked, the allocation index is 0, the replacement pointer is 0, the probe tag register is 0 and the status word reads 0.
- R2: The register window has three offsets. Offset 0x0 is the 32-bit probe register, which reads back as written; its low 20 bits are the tag it searches for. Offset 0x4 is the command word: it reads as the allocation index in bits 31:16, with every other bit reading 0, and writes to bits 31:16 and to reserved bits 15:9 have no effect. Offset 0x8 is the status word: bit 0 is the probe-hit flag and bit 1 is the all-locked flag. Any other offset reads 0.
- R3: The lookup port reports a hit in the same cycle when a valid slot holds the presented tag. On a hit it returns that slot's index and physical page. When several valid slots match, the lowest index wins. On a miss the page output is 0.
- R4: A pulse on the entry write port stores tag, page and lock into the slot named by the allocation index and marks it valid. The replacement pointer then becomes that index plus one, modulo the slot count.
- R5: Writing 1 to command bit 0 loads the allocation index with the current victim.
- R6: Writing 1 to command bit 8 searches the valid slots for the probe tag. On a hit, the allocation index becomes the lowest matching index and the probe-hit flag becomes 1. On a miss, the allocation index becomes the victim and the flag becomes 0. The replacement pointer is unchanged.
- R7: Writing 1 to command bit 7 invalidates and unlocks every slot and returns the replacement pointer to 0. It leaves the allocation index unchanged.
- R8: Writing 1 to command bit 6 invalidates exactly the slots whose lock flag is clear. Locked slots and the replacement pointer are kept.
- R9: The victim is the first slot with a clear lock flag, counting upward from the replacement pointer and wrapping around. When all slots are locked, the all-locked flag is 1 and the victim is the pointer itself.
- R10: When several command bits are written together, only the highest-priority one acts. The order is bit 7, then bit 6, then bit 8, then bit 0. An entry write in the same cycle as either invalidate command is dropped and does not move the pointer.
- R11: A fault pulse loads the allocation index with the fault index. It overrides a search or victim load in the same cycle, but a search in that cycle still updates the probe-hit flag.
- R12: Lookups have no effect on the replacement pointer or on the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ent_wr | input | 1 | Entry write strobe, targets the allocation index |
| ent_vtag | input | 20 | Virtual tag to store |
| ent_ppage | input | 20 | Physical page to store |
| ent_lock | input | 1 | Lock flag to store |
| err_valid | input | 1 | Translation fault pulse |
| err_idx | input | 4 | Slot index that caused the fault |
| lk_vtag | input | 20 | Lookup virtual tag |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 4 | Lookup hit index |
| lk_ppage | output | 20 | Lookup physical page |

## Verification
The hardest state to reach from the ports is a buffer whose sixteen slots are all locked. It takes sixteen pairs of victim load and locked entry write. Along the way the victim must follow the pointer past every slot already locked, and the pointer must wrap back to 0. The bench also sets up cases where the victim must skip a locked slot that sits right at the pointer. It then writes commands that collide in the same cycle: several command bits at once, a fault together with a missing search, and an invalidate together with an entry write. In each case the bench reads the allocation index afterwards, and the value it finds tells which command acted. A behavioural model in the bench follows every cycle and compares the lookup outputs and the register read data at each falling edge.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;

    localparam int TLB_ENTRIES = 16;
    localparam int TLB_VTAG_W  = 20;
    localparam int TLB_PPAGE_W = 20;
    localparam int REG_AW      = 4;
    localparam int REG_DW      = 32;

    localparam logic [REG_AW-1:0] OFS_PROBE = 4'h0;
    localparam logic [REG_AW-1:0] OFS_OP    = 4'h4;
    localparam logic [REG_AW-1:0] OFS_STAT  = 4'h8;

    localparam int OPB_UPD       = 0;
    localparam int OPB_CLRUNL    = 6;
    localparam int OPB_CLRALL    = 7;
    localparam int OPB_SEARCH    = 8;
    localparam int OPB_ALLOC_LSB = 16;

    localparam int STB_HIT     = 0;
    localparam int STB_ALLLOCK = 1;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_CLR_ALL,
        CMD_CLR_UNL,
        CMD_SEARCH,
        CMD_UPD_ALLOC
    } op_cmd_e;

    typedef struct packed {
        op_cmd_e cmd;
        logic    probe_wr;
    } reg_req_t;

    function automatic op_cmd_e pick_cmd(input logic clr_all, input logic clr_unl,
                                         input logic search, input logic upd);
        if (clr_all)      return CMD_CLR_ALL;
        else if (clr_unl) return CMD_CLR_UNL;
        else if (search)  return CMD_SEARCH;
        else if (upd)     return CMD_UPD_ALLOC;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/tlb_op_decode.sv
module tlb_op_decode
    import tlb_maint_pkg::*;
(
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output reg_req_t          req
);
    logic op_sel;

    assign op_sel = reg_wr && (reg_addr == OFS_OP);

    always_comb begin
        req.probe_wr = reg_wr && (reg_addr == OFS_PROBE);
        req.cmd      = CMD_NONE;
        if (op_sel) begin
            req.cmd = pick_cmd(reg_wdata[OPB_CLRALL], reg_wdata[OPB_CLRUNL],
                               reg_wdata[OPB_SEARCH], reg_wdata[OPB_UPD]);
        end
    end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int N_ENT   = 16,
    parameter int VTAG_W  = 20,
    parameter int PPAGE_W = 20,
    localparam int IDX_W  = $clog2(N_ENT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_all,
    input  logic                     clr_unl,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [VTAG_W-1:0]        wr_vtag,
    input  logic [PPAGE_W-1:0]       wr_ppage,
    input  logic                     wr_lock,
    output logic [N_ENT-1:0]         valid_vec,
    output logic [N_ENT-1:0]         lock_vec,
    output logic [N_ENT*VTAG_W-1:0]  vtag_flat,
    output logic [N_ENT*PPAGE_W-1:0] ppage_flat
);
    typedef struct packed {
        logic               valid;
        logic               lock;
        logic [VTAG_W-1:0]  vtag;
        logic [PPAGE_W-1:0] ppage;
    } slot_t;

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        slot_t slot_q;

        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                slot_q <= '0;
            end else if (clr_unl) begin
                if (!slot_q.lock) slot_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q <= '{valid: 1'b1, lock: wr_lock, vtag: wr_vtag, ppage: wr_ppage};
            end
        end

        assign valid_vec[g]                     = slot_q.valid;
        assign lock_vec[g]                      = slot_q.lock;
        assign vtag_flat[g*VTAG_W +: VTAG_W]    = slot_q.vtag;
        assign ppage_flat[g*PPAGE_W +: PPAGE_W] = slot_q.ppage;
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N_ENT  = 16,
    parameter int VTAG_W = 20,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0]        valid_vec,
    input  logic [N_ENT*VTAG_W-1:0] vtag_flat,
    input  logic [VTAG_W-1:0]       key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (valid_vec[i] && (vtag_flat[i*VTAG_W +: VTAG_W] == key)) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
    parameter int N_ENT  = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             adv_en,
    input  logic [IDX_W-1:0] adv_from,
    input  logic [N_ENT-1:0] lock_vec,
    output logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] victim,
    output logic             all_locked
);
    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clr_all) ptr_q <= '0;
        else if (adv_en)    ptr_q <= adv_from + 1'b1;
    end

    always_comb begin
        logic [IDX_W-1:0] cand;
        victim = ptr_q;
        for (int k = N_ENT - 1; k >= 0; k--) begin
            cand = ptr_q + IDX_W'(k);
            if (!lock_vec[cand]) victim = cand;
        end
    end

    assign all_locked = &lock_vec;
    assign ptr        = ptr_q;
endmodule

// File: rtl/tlb_maint_ctrl.sv
module tlb_maint_ctrl
    import tlb_maint_pkg::*;
#(
    parameter int N_ENT   = TLB_ENTRIES,
    parameter int VTAG_W  = TLB_VTAG_W,
    parameter int PPAGE_W = TLB_PPAGE_W,
    localparam int IDX_W  = $clog2(N_ENT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0]  reg_rdata,
    input  logic               ent_wr,
    input  logic [VTAG_W-1:0]  ent_vtag,
    input  logic [PPAGE_W-1:0] ent_ppage,
    input  logic               ent_lock,
    input  logic               err_valid,
    input  logic [IDX_W-1:0]   err_idx,
    input  logic [VTAG_W-1:0]  lk_vtag,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [PPAGE_W-1:0] lk_ppage
);
    reg_req_t                 req;
    logic                     clr_all, clr_unl, do_search, do_upd, do_wr;
    logic [REG_DW-1:0]        probe_q;
    logic [IDX_W-1:0]         alloc_q;
    logic                     hit_q;
    logic [N_ENT-1:0]         valid_vec, lock_vec;
    logic [N_ENT*VTAG_W-1:0]  vtag_flat;
    logic [N_ENT*PPAGE_W-1:0] ppage_flat;
    logic                     srch_hit;
    logic [IDX_W-1:0]         srch_idx;
    logic [IDX_W-1:0]         ptr, victim;
    logic                     all_locked;

    tlb_op_decode u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .req       (req)
    );

    assign clr_all   = (req.cmd == CMD_CLR_ALL);
    assign clr_unl   = (req.cmd == CMD_CLR_UNL);
    assign do_search = (req.cmd == CMD_SEARCH);
    assign do_upd    = (req.cmd == CMD_UPD_ALLOC);
    assign do_wr     = ent_wr && !clr_all && !clr_unl;

    tlb_entry_array #(.N_ENT(N_ENT), .VTAG_W(VTAG_W), .PPAGE_W(PPAGE_W)) u_arr (
        .clk        (clk),
        .rst        (rst),
        .clr_all    (clr_all),
        .clr_unl    (clr_unl),
        .wr_en      (do_wr),
        .wr_idx     (alloc_q),
        .wr_vtag    (ent_vtag),
        .wr_ppage   (ent_ppage),
        .wr_lock    (ent_lock),
        .valid_vec  (valid_vec),
        .lock_vec   (lock_vec),
        .vtag_flat  (vtag_flat),
        .ppage_flat (ppage_flat)
    );

    tlb_match #(.N_ENT(N_ENT), .VTAG_W(VTAG_W)) u_lk_match (
        .valid_vec (valid_vec),
        .vtag_flat (vtag_flat),
        .key       (lk_vtag),
        .hit       (lk_hit),
        .idx       (lk_idx)
    );

    tlb_match #(.N_ENT(N_ENT), .VTAG_W(VTAG_W)) u_probe_match (
        .valid_vec (valid_vec),
        .vtag_flat (vtag_flat),
        .key       (probe_q[VTAG_W-1:0]),
        .hit       (srch_hit),
        .idx       (srch_idx)
    );

    tlb_repl #(.N_ENT(N_ENT)) u_repl (
        .clk        (clk),
        .rst        (rst),
        .clr_all    (clr_all),
        .adv_en     (do_wr),
        .adv_from   (alloc_q),
        .lock_vec   (lock_vec),
        .ptr        (ptr),
        .victim     (victim),
        .all_locked (all_locked)
    );

    assign lk_ppage = lk_hit ? ppage_flat[int'(lk_idx)*PPAGE_W +: PPAGE_W] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            probe_q <= '0;
            alloc_q <= '0;
            hit_q   <= 1'b0;
        end else begin
            if (req.probe_wr) probe_q <= reg_wdata;
            if (do_search)    hit_q   <= srch_hit;
            if (err_valid)      alloc_q <= err_idx;
            else if (do_search) alloc_q <= srch_hit ? srch_idx : victim;
            else if (do_upd)    alloc_q <= victim;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_PROBE: reg_rdata = probe_q;
            OFS_OP:    reg_rdata[OPB_ALLOC_LSB +: IDX_W] = alloc_q;
            OFS_STAT: begin
                reg_rdata[STB_HIT]     = hit_q;
                reg_rdata[STB_ALLLOCK] = all_locked;
            end
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tlb_maint_chk.sv
module tlb_maint_chk
    import tlb_maint_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic [REG_DW-1:0] reg_rdata,
    input logic              ent_wr,
    input logic              err_valid,
    input logic [IDX_W-1:0]  err_idx,
    input logic              lk_hit,
    input logic [IDX_W-1:0]  lk_idx,
    input logic [N_ENT-1:0]  valid_vec,
    input logic [N_ENT-1:0]  lock_vec,
    input logic [IDX_W-1:0]  ptr,
    input logic [IDX_W-1:0]  victim,
    input logic              all_locked,
    input logic [IDX_W-1:0]  alloc_q
);
    logic op_wr, clr_all_cmd, clr_unl_cmd, srch_cmd;

    assign op_wr       = reg_wr && (reg_addr == OFS_OP);
    assign clr_all_cmd = op_wr && reg_wdata[OPB_CLRALL];
    assign clr_unl_cmd = op_wr && reg_wdata[OPB_CLRUNL] && !reg_wdata[OPB_CLRALL];
    assign srch_cmd    = op_wr && reg_wdata[OPB_SEARCH]
                         && !reg_wdata[OPB_CLRALL] && !reg_wdata[OPB_CLRUNL];

    assert_op_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_OP) |-> (reg_rdata[15:0] == 16'h0));

    assert_lookup_on_valid_R3: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> valid_vec[lk_idx]);

    assert_write_moves_ptr_R4: assert property (@(posedge clk) disable iff (rst)
        (ent_wr && !clr_all_cmd && !clr_unl_cmd) |=> (ptr == IDX_W'($past(alloc_q) + 1'b1)));

    assert_search_holds_ptr_R6: assert property (@(posedge clk) disable iff (rst)
        (srch_cmd && !ent_wr) |=> $stable(ptr));

    assert_clr_all_empty_R7: assert property (@(posedge clk) disable iff (rst)
        clr_all_cmd |=> ((valid_vec == '0) && (lock_vec == '0) && (ptr == '0)));

    assert_clr_unl_keeps_locked_R8: assert property (@(posedge clk) disable iff (rst)
        clr_unl_cmd |=> (valid_vec == $past(lock_vec)));

    assert_victim_unlocked_R9: assert property (@(posedge clk) disable iff (rst)
        !all_locked |-> !lock_vec[victim]);

    assert_all_locked_victim_R9: assert property (@(posedge clk) disable iff (rst)
        all_locked |-> (victim == ptr));

    assert_err_loads_alloc_R11: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> (alloc_q == $past(err_idx)));
endmodule

bind tlb_maint_ctrl tlb_maint_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ent_wr     (ent_wr),
    .err_valid  (err_valid),
    .err_idx    (err_idx),
    .lk_hit     (lk_hit),
    .lk_idx     (lk_idx),
    .valid_vec  (valid_vec),
    .lock_vec   (lock_vec),
    .ptr        (ptr),
    .victim     (victim),
    .all_locked (all_locked),
    .alloc_q    (alloc_q)
);

// File: tb/tlb_maint_ctrl_tb_top.sv
`timescale 1ns/1ps
module tlb_maint_ctrl_tb_top;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ent_wr = 1'b0;
    logic [19:0] ent_vtag = '0;
    logic [19:0] ent_ppage = '0;
    logic        ent_lock = 1'b0;
    logic        err_valid = 1'b0;
    logic [3:0]  err_idx = '0;
    logic [19:0] lk_vtag = '0;
    logic        lk_hit;
    logic [3:0]  lk_idx;
    logic [19:0] lk_ppage;

    int ntest = 0;
    int nfail = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tlb_maint_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ent_wr(ent_wr),
        .ent_vtag(ent_vtag), .ent_ppage(ent_ppage), .ent_lock(ent_lock),
        .err_valid(err_valid), .err_idx(err_idx), .lk_vtag(lk_vtag),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppage(lk_ppage)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_valid [NE];
    bit          m_lock  [NE];
    int          m_tag   [NE];
    int          m_pp    [NE];
    int          m_ptr, m_alloc;
    bit          m_hit;
    logic [31:0] m_probe;

    function automatic int m_find(input int t);
        for (int i = 0; i < NE; i++) if (m_valid[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic bit m_all_locked();
        for (int i = 0; i < NE; i++) if (!m_lock[i]) return 0;
        return 1;
    endfunction

    function automatic int m_victim();
        if (m_all_locked()) return m_ptr;
        for (int k = 0; k < NE; k++) if (!m_lock[(m_ptr + k) % NE]) return (m_ptr + k) % NE;
        return m_ptr;
    endfunction

    function automatic logic [31:0] m_rdata(input logic [3:0] a);
        case (a)
            4'h0: return m_probe;
            4'h4: return 32'(m_alloc) << 16;
            4'h8: return {30'd0, m_all_locked(), m_hit};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NE; i++) begin
                m_valid[i] = 0; m_lock[i] = 0; m_tag[i] = 0; m_pp[i] = 0;
            end
            m_ptr = 0; m_alloc = 0; m_hit = 0; m_probe = '0;
        end else begin
            int cmd, vic, found, nxt;
            cmd = 0;
            if (reg_wr && reg_addr == 4'h4) begin
                if (reg_wdata[7])      cmd = 1;
                else if (reg_wdata[6]) cmd = 2;
                else if (reg_wdata[8]) cmd = 3;
                else if (reg_wdata[0]) cmd = 4;
            end
            vic   = m_victim();
            found = m_find(int'(m_probe[19:0]));
            nxt   = m_alloc;
            if (err_valid)     nxt = err_idx;
            else if (cmd == 3) nxt = (found >= 0) ? found : vic;
            else if (cmd == 4) nxt = vic;
            if (cmd == 3) m_hit = (found >= 0);
            if (reg_wr && reg_addr == 4'h0) m_probe = reg_wdata;
            if (cmd == 1) begin
                for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_lock[i] = 0; end
                m_ptr = 0;
            end else if (cmd == 2) begin
                for (int i = 0; i < NE; i++) if (!m_lock[i]) m_valid[i] = 0;
            end else if (ent_wr) begin
                m_valid[m_alloc] = 1; m_lock[m_alloc] = ent_lock;
                m_tag[m_alloc] = int'(ent_vtag); m_pp[m_alloc] = int'(ent_ppage);
                m_ptr = (m_alloc + 1) % NE;
            end
            m_alloc = nxt;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        ntest++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            int f;
            f = m_find(int'(lk_vtag));
            chk("R3", "lookup hit", int'(lk_hit), int'(f >= 0));
            if (f >= 0) chk("R3", "lookup idx", int'(lk_idx), f);
            chk("R3", "lookup page", int'(lk_ppage), (f >= 0) ? m_pp[f] : 0);
            chk("R2", "read data", int'(reg_rdata), int'(m_rdata(reg_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #1;
        reg_wr = 0; ent_wr = 0; err_valid = 0;
    endtask

    task automatic op(input logic [31:0] w);
        reg_addr = 4'h4; reg_wdata = w; reg_wr = 1; step();
    endtask

    task automatic set_probe(input logic [31:0] w);
        reg_addr = 4'h0; reg_wdata = w; reg_wr = 1; step();
    endtask

    task automatic wr_ent(input int t, input int p, input bit lk);
        ent_vtag = 20'(t); ent_ppage = 20'(p); ent_lock = lk; ent_wr = 1; step();
    endtask

    task automatic fault(input int i);
        err_idx = 4'(i); err_valid = 1; step();
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; @(negedge clk); d = reg_rdata;
    endtask

    task automatic look(input int t, input string req, input int ehit, input int eidx, input int epp);
        lk_vtag = 20'(t); @(negedge clk);
        chk(req, "lookup hit", int'(lk_hit), ehit);
        if (ehit != 0) begin
            chk(req, "lookup idx", int'(lk_idx), eidx);
            chk(req, "lookup page", int'(lk_ppage), epp);
        end
    endtask

    task automatic exp_alloc(input string req, input int e);
        logic [31:0] d;
        rd(4'h4, d);
        chk(req, "alloc index", int'(d[31:16]), e);
    endtask

    task automatic exp_stat(input string req, input int e);
        logic [31:0] d;
        rd(4'h8, d);
        chk(req, "status", int'(d), e);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            ntest++; nfail++;
            $display("FAIL watchdog R1-path run did not finish actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        exp_alloc("R1", 0);
        exp_stat("R1", 0);
        rd(4'h0, d); chk("R1", "probe reg", int'(d), 0);
        look(0, "R1", 0, 0, 0);

        // R4/R5 fill through victim loads
        op(32'h1); exp_alloc("R5", 0); wr_ent('h100, 'hA0, 0);
        op(32'h1); exp_alloc("R5", 1); wr_ent('h101, 'hA1, 1);
        op(32'h1); exp_alloc("R4", 2); wr_ent('h102, 'hA2, 0);
        op(32'h1); exp_alloc("R4", 3); wr_ent('h102, 'hA3, 0);

        // R3 lookup incl. duplicate tag
        look('h102, "R3", 1, 2, 'hA2);
        look('h101, "R3", 1, 1, 'hA1);
        look('h777, "R3", 0, 0, 0);

        // R11 fault loads alloc; locked write at 9
        fault(9); exp_alloc("R11", 9);
        wr_ent('h109, 'hA9, 1);
        fault(0); wr_ent('h100, 'hB0, 0);
        look('h100, "R4", 1, 0, 'hB0);

        // R9 victim skips locked slot 1 at pointer
        op(32'h1); exp_alloc("R9", 2);

        // R6 search hit / miss
        set_probe(32'h109); op(32'h100);
        exp_alloc("R6", 9); exp_stat("R6", 1);
        set_probe(32'h555); op(32'h100);
        exp_alloc("R6", 2); exp_stat("R6", 0);

        // R12 lookups leave victim unchanged; R6 search left pointer
        look('h109, "R12", 1, 9, 'hA9);
        look('h100, "R12", 1, 0, 'hB0);
        op(32'h1); exp_alloc("R12", 2);

        // R10 search beats update
        set_probe(32'h109); op(32'h101);
        exp_alloc("R10", 9); exp_stat("R10", 1);

        // R10 clear-unlocked beats search; R8 effect
        set_probe(32'h555); op(32'h140);
        exp_alloc("R10", 9); exp_stat("R10", 1);
        look('h100, "R8", 0, 0, 0);
        look('h102, "R8", 0, 0, 0);
        look('h101, "R8", 1, 1, 'hA1);
        look('h109, "R8", 1, 9, 'hA9);

        // R11 fault with a missing search
        reg_addr = 4'h4; reg_wdata = 32'h100; reg_wr = 1; err_idx = 4'd5; err_valid = 1; step();
        exp_alloc("R11", 5); exp_stat("R11", 0);

        // R10 invalidate drops same-cycle entry write
        op(32'h1); exp_alloc("R10", 2);
        reg_addr = 4'h4; reg_wdata = 32'h40; reg_wr = 1;
        ent_vtag = 20'h222; ent_ppage = 20'hCC; ent_lock = 0; ent_wr = 1; step();
        look('h222, "R10", 0, 0, 0);
        op(32'h1); exp_alloc("R10", 2);

        // R7 clear-all beats update, wipes locks, pointer to 0
        op(32'h81); exp_alloc("R7", 2);
        look('h101, "R7", 0, 0, 0);
        look('h109, "R7", 0, 0, 0);
        op(32'h1); exp_alloc("R7", 0);

        // R9 lock every slot
        for (int i = 0; i < NE; i++) begin
            op(32'h1); exp_alloc("R4", i);
            wr_ent('h300 + i, 'hC0 + i, 1);
        end
        exp_stat("R9", 2);
        op(32'h1); exp_alloc("R9", 0);
        op(32'h40); look('h30F, "R8", 1, 15, 'hCF);
        exp_stat("R8", 2);
        op(32'h80); exp_stat("R7", 0);
        look('h300, "R7", 0, 0, 0);

        // R2 reserved / read-only bits and unused offsets
        fault(6);
        op(32'hFFFF_FE00);
        rd(4'h4, d); chk("R2", "op readback", int'(d), 32'h0006_0000);
        rd(4'hC, d); chk("R2", "unused offset", int'(d), 0);
        set_probe(32'hFFFA_BCDE);
        rd(4'h0, d); chk("R2", "probe readback", int'(d), 32'hFFFA_BCDE);

        step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule